// File: doc/BRIEF.md
# ECC Error Event Capture Unit

This block sits beside a flash memory controller and keeps a diagnostic record of the most recent ECC event that software has asked to track. The controller raises a one-cycle strobe for each access that hit an ECC event. There is one strobe for a single-bit error that was corrected and one for a non-correctable error. With the strobe come the access address, the number of the bus master, that master's attribute byte and the access data.

Two configuration enables, one per event type, decide which events are recorded. An event whose type is enabled loads all four capture registers in the same cycle and raises the sticky flag that matches its type. Every later enabled event replaces the earlier record. Software reads the record through a small register port. The capture registers ignore writes. The flags are cleared by writing 1 to their bit in a status byte.

Top module: `ecc_capture_bank`

## Requirements
- R1: An event whose type enable is low changes neither the captured address, master, attributes and data nor either flag.
- R2: An enabled event loads the address, master number, attributes and data together. Afterwards they read back at offsets 0x50 (address), 0x56 (master), 0x57 (attributes) and 0x58 (data). Narrower fields are zero-extended to 32 bits.
- R3: A later enabled event overwrites the whole earlier record, so reads always describe the last enabled event.
- R4: An enabled single-bit event sets flag `sbc_flag`, which is status bit 1. An enabled non-correctable event sets flag `ncr_flag`, which is status bit 0. The status byte is at offset 0x43. Both flags stay set until they are cleared.
- R5: Writes to offsets 0x50, 0x56, 0x57 and 0x58 are ignored. The captured values read back unchanged after such a write.
- R6: A read of the master-number byte returns zero in bits 31:4, whether or not any event has been captured.
- R7: After reset both flags are 0. Writing 0x43 with bit 1 set clears `sbc_flag`, and writing it with bit 0 set clears `ncr_flag`. A 0 in a bit leaves that flag unchanged.
- R8: If enabled single-bit and non-correctable events arrive in the same cycle, only the non-correctable event is captured and only `ncr_flag` is set. If the non-correctable type is disabled, the single-bit event is captured instead.
- R9: If a flag is set and cleared in the same cycle, the set wins.
- R10: `reg_rdata` carries the addressed value in the cycle after `reg_rd` is high. In any cycle that follows a cycle with `reg_rd` low, it is zero. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_sbc | input | 1 | Single-bit corrected event strobe |
| evt_ncr | input | 1 | Non-correctable event strobe |
| evt_addr | input | 32 | Faulting access address |
| evt_master | input | MASTER_W | Bus master number of the access |
| evt_attr | input | ATTR_W | Master attributes of the access |
| evt_data | input | DATA_W | Access data |
| cfg_sbc_en | input | 1 | Enable capture of single-bit events |
| cfg_ncr_en | input | 1 | Enable capture of non-correctable events |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | RA_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| sbc_flag | output | 1 | Sticky single-bit event flag |
| ncr_flag | output | 1 | Sticky non-correctable event flag |

## Verification
The bench builds the block with DATA_W at 24, which is narrower than the 32-bit read bus, so the zero-extension of the data register is exercised along with that of the master and attribute bytes. MASTER_W stays at 4 so that the four always-zero upper bits of the master byte can be seen on reads. Random mixes of both strobes, both enables and writes to every offset cover the case where both strobes arrive in the same cycle and the case where a flag is set and cleared in the same cycle.

// File: rtl/ecc_capture_bank.sv
module ecc_capture_bank #(
  parameter int DATA_W   = 32,
  parameter int MASTER_W = 4,
  parameter int ATTR_W   = 8,
  parameter int RA_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_sbc,
  input  logic                evt_ncr,
  input  logic [31:0]         evt_addr,
  input  logic [MASTER_W-1:0] evt_master,
  input  logic [ATTR_W-1:0]   evt_attr,
  input  logic [DATA_W-1:0]   evt_data,
  input  logic                cfg_sbc_en,
  input  logic                cfg_ncr_en,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [RA_W-1:0]     reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                sbc_flag,
  output logic                ncr_flag
);
  localparam logic [RA_W-1:0] OFS_STAT = RA_W'(8'h43);
  localparam logic [RA_W-1:0] OFS_ADDR = RA_W'(8'h50);
  localparam logic [RA_W-1:0] OFS_MST  = RA_W'(8'h56);
  localparam logic [RA_W-1:0] OFS_ATTR = RA_W'(8'h57);
  localparam logic [RA_W-1:0] OFS_DATA = RA_W'(8'h58);

  logic [31:0]         cap_addr;
  logic [MASTER_W-1:0] cap_mst;
  logic [ATTR_W-1:0]   cap_attr;
  logic [DATA_W-1:0]   cap_data;
  logic [31:0]         rd_mux;

  wire take_ncr = evt_ncr & cfg_ncr_en;
  wire take_sbc = evt_sbc & cfg_sbc_en & ~take_ncr;
  wire take     = take_ncr | take_sbc;
  wire stat_wr  = reg_wr && (reg_addr == OFS_STAT);
  wire unused_wdata = ^reg_wdata[31:2];

  always_ff @(posedge clk) begin
    if (take) begin
      cap_addr <= evt_addr;
      cap_mst  <= evt_master;
      cap_attr <= evt_attr;
      cap_data <= evt_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbc_flag <= 1'b0;
      ncr_flag <= 1'b0;
    end else begin
      sbc_flag <= take_sbc | (sbc_flag & ~(stat_wr & reg_wdata[1]));
      ncr_flag <= take_ncr | (ncr_flag & ~(stat_wr & reg_wdata[0]));
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT: rd_mux = {30'd0, sbc_flag, ncr_flag};
      OFS_ADDR: rd_mux = cap_addr;
      OFS_MST:  rd_mux = 32'(cap_mst);
      OFS_ATTR: rd_mux = 32'(cap_attr);
      OFS_DATA: rd_mux = 32'(cap_data);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= reg_rd ? rd_mux : '0;
  end
endmodule

module ecc_capture_bank_chk #(
  parameter int DATA_W   = 32,
  parameter int MASTER_W = 4,
  parameter int ATTR_W   = 8,
  parameter int RA_W     = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                evt_sbc,
  input logic                evt_ncr,
  input logic                cfg_sbc_en,
  input logic                cfg_ncr_en,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [RA_W-1:0]     reg_addr,
  input logic [31:0]         reg_wdata,
  input logic [31:0]         reg_rdata,
  input logic                sbc_flag,
  input logic                ncr_flag,
  input logic [31:0]         cap_addr,
  input logic [MASTER_W-1:0] cap_mst,
  input logic [ATTR_W-1:0]   cap_attr,
  input logic [DATA_W-1:0]   cap_data
);
  wire en_ncr = evt_ncr && cfg_ncr_en;
  wire en_sbc = evt_sbc && cfg_sbc_en;

  // R1
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_ncr || en_sbc) |=> $stable(cap_addr) && $stable(cap_mst) && $stable(cap_attr) && $stable(cap_data));

  // R4
  sbc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_sbc && !en_ncr) |=> sbc_flag);

  // R8
  ncr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_ncr |=> ncr_flag && (sbc_flag == $past(sbc_flag && !(reg_wr && reg_addr == RA_W'(8'h43) && reg_wdata[1]))));

  // R7
  sbc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sbc_flag) |-> $past(reg_wr && reg_addr == RA_W'(8'h43) && reg_wdata[1]));

  // R7
  ncr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ncr_flag) |-> $past(reg_wr && reg_addr == RA_W'(8'h43) && reg_wdata[0]));

  // R6
  mst_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == RA_W'(8'h56)) |=> reg_rdata[31:MASTER_W] == '0);

  // R10
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> reg_rdata == 32'd0);
endmodule

bind ecc_capture_bank ecc_capture_bank_chk #(
  .DATA_W(DATA_W), .MASTER_W(MASTER_W), .ATTR_W(ATTR_W), .RA_W(RA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_sbc(evt_sbc), .evt_ncr(evt_ncr),
  .cfg_sbc_en(cfg_sbc_en), .cfg_ncr_en(cfg_ncr_en), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .sbc_flag(sbc_flag), .ncr_flag(ncr_flag),
  .cap_addr(cap_addr), .cap_mst(cap_mst), .cap_attr(cap_attr), .cap_data(cap_data)
);

// File: tb/ecc_capture_bank_bench.sv
module ecc_capture_bank_bench;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_sbc = 0, evt_ncr = 0, cfg_sbc_en = 0, cfg_ncr_en = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] evt_addr = '0, reg_wdata = '0, reg_rdata;
  logic [3:0] evt_master = '0;
  logic [7:0] evt_attr = '0, reg_addr = '0;
  logic [DATA_W-1:0] evt_data = '0;
  logic sbc_flag, ncr_flag;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_addr;
  logic [3:0]  m_mst;
  logic [7:0]  m_attr;
  logic [DATA_W-1:0] m_data;
  logic m_sbc = 0, m_ncr = 0;

  always #(CLK_P/2) clk = ~clk;

  ecc_capture_bank #(.DATA_W(DATA_W)) u_ecc_capture_bank (
    .clk(clk), .rst_n(rst_n), .evt_sbc(evt_sbc), .evt_ncr(evt_ncr),
    .evt_addr(evt_addr), .evt_master(evt_master), .evt_attr(evt_attr),
    .evt_data(evt_data), .cfg_sbc_en(cfg_sbc_en), .cfg_ncr_en(cfg_ncr_en),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sbc_flag(sbc_flag), .ncr_flag(ncr_flag)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h43: return {30'd0, m_sbc, m_ncr};
      8'h50: return m_addr;
      8'h56: return 32'(m_mst);
      8'h57: return 32'(m_attr);
      8'h58: return 32'(m_data);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic n, input logic w,
                     input logic [7:0] wa, input logic [31:0] wd);
    logic tn, ts;
    evt_sbc = s; evt_ncr = n;
    evt_addr = $urandom; evt_master = 4'($urandom);
    evt_attr = 8'($urandom); evt_data = DATA_W'($urandom);
    reg_wr = w; reg_addr = wa; reg_wdata = wd;
    @(negedge clk);
    tn = n & cfg_ncr_en;
    ts = s & cfg_sbc_en & ~tn;
    if (tn | ts) begin
      m_addr = evt_addr; m_mst = evt_master; m_attr = evt_attr; m_data = evt_data;
    end
    m_sbc = ts | (m_sbc & ~(w && wa == 8'h43 && wd[1]));
    m_ncr = tn | (m_ncr & ~(w && wa == 8'h43 && wd[0]));
    evt_sbc = 0; evt_ncr = 0; reg_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    check(tag, reg_rdata, exp_read(a));
  endtask

  task automatic rd_all(input string tag);
    rd({tag, " addr"}, 8'h50);
    rd({tag, " master"}, 8'h56);
    rd({tag, " attr"}, 8'h57);
    rd({tag, " data"}, 8'h58);
    rd({tag, " status"}, 8'h43);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R7 reset state
    check("R7 reset sbc_flag", 32'(sbc_flag), 0);
    check("R7 reset ncr_flag", 32'(ncr_flag), 0);
    rd("R7 reset status", 8'h43);
    // R6 before any capture
    reg_rd = 1; reg_addr = 8'h56; @(negedge clk); reg_rd = 0;
    check("R6 master upper bits at reset", {4'd0, reg_rdata[31:4]}, 0);
    // R10 unmapped and idle
    rd("R10 unmapped offset", 8'h44);
    @(negedge clk);
    check("R10 idle rdata", reg_rdata, 0);

    // R2 first enabled capture
    cfg_sbc_en = 1; cfg_ncr_en = 1;
    cyc(1, 0, 0, 0, 0);
    rd_all("R2 sbc capture");
    check("R4 sbc_flag set", 32'(sbc_flag), 1);
    check("R4 ncr_flag clear", 32'(ncr_flag), 0);

    // R1 disabled event
    cfg_sbc_en = 0;
    cyc(1, 0, 0, 0, 0);
    rd_all("R1 disabled sbc");
    cfg_ncr_en = 0;
    cyc(0, 1, 0, 0, 0);
    rd_all("R1 disabled ncr");
    check("R1 ncr_flag stays clear", 32'(ncr_flag), 0);

    // R3 overwrite
    cfg_ncr_en = 1;
    cyc(0, 1, 0, 0, 0);
    rd_all("R3 overwrite by ncr");
    check("R4 both flags sticky", {30'd0, sbc_flag, ncr_flag}, 3);

    // R5 ignored writes
    cyc(0, 0, 1, 8'h50, 32'hFFFF_FFFF);
    cyc(0, 0, 1, 8'h56, 32'hFFFF_FFFF);
    cyc(0, 0, 1, 8'h57, 32'hA5A5_A5A5);
    cyc(0, 0, 1, 8'h58, 32'h1234_5678);
    rd_all("R5 after writes");

    // R7 clear with zero and with one
    cyc(0, 0, 1, 8'h43, 32'h0);
    rd("R7 write zero keeps flags", 8'h43);
    cyc(0, 0, 1, 8'h43, 32'h2);
    rd("R7 clear sbc only", 8'h43);
    cyc(0, 0, 1, 8'h43, 32'h1);
    rd("R7 clear ncr", 8'h43);

    // R8 same-cycle priority
    cfg_sbc_en = 1;
    cyc(1, 1, 0, 0, 0);
    rd_all("R8 both enabled");
    check("R8 sbc_flag not set", 32'(sbc_flag), 0);
    cyc(0, 0, 1, 8'h43, 32'h3);
    cfg_ncr_en = 0;
    cyc(1, 1, 0, 0, 0);
    rd_all("R8 ncr disabled");
    check("R8 sbc taken", 32'(sbc_flag), 1);

    // R9 set beats clear
    cyc(1, 0, 1, 8'h43, 32'h3);
    rd("R9 set wins", 8'h43);
    check("R9 sbc_flag", 32'(sbc_flag), 1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      int op;
      cfg_sbc_en = 1'($urandom); cfg_ncr_en = 1'($urandom);
      op = $urandom_range(0, 2);
      case ($urandom_range(0, 5))
        0: a = 8'h43; 1: a = 8'h50; 2: a = 8'h56;
        3: a = 8'h57; 4: a = 8'h58; default: a = 8'($urandom);
      endcase
      if (op == 0) cyc(1'($urandom), 1'($urandom), 0, 0, 0);
      else if (op == 1) cyc(1'($urandom), 1'($urandom), 1, a, $urandom);
      else rd("R3 random read", a);
    end
    rd_all("R2 random final");

    finish_run();
  end
endmodule